// File: doc/BRIEF.md
# Opcode-Indexed Horizontal Microsequencer

This block steps through horizontal microcode for one instruction at a time. A latched opcode supplies the upper bits of the microcode address. A small step counter supplies the lower bits. The block drives the address out to an external microcode array and takes the addressed word back. The word is registered onto the control lines of the datapath, and each bit of the word drives one line.

Two bits of the fetched word act on the sequencer itself. The end bit (bit 15) sends the step counter back to zero at the next clock edge, so an instruction can take anywhere from 2 to 16 microinstructions. The load bit (bit 14) captures a new opcode, but only while the counter sits at step zero. Step zero of every opcode therefore holds the shared fetch microcode. Reset starts execution at address zero. A fetch flag, aligned with the control word, marks cycles in which that word came from step zero.

The contents of the microcode array, the datapath and any condition logic sit outside this block.

Top module: `useq_top`

## Requirements
- R1: While reset is high, and at the first sample after it, the address output is zero, the control output is zero and the fetch flag is low.
- R2: The address output is the latched opcode in bits [11:4] concatenated with the step counter in bits [3:0].
- R3: When the fetched word has bit 15 (end) clear, the step field of the address advances by one at the next edge.
- R4: When the fetched word has bit 15 (end) set, the step field is zero after the next edge.
- R5: At step 15 with bit 15 clear, the step field wraps to zero.
- R6: At step zero with bit 14 (load) set, the opcode field after the edge equals the opcode input sampled at that edge.
- R7: Bit 14 (load) at a nonzero step has no effect: the opcode field keeps its value.
- R8: The control output equals the microcode word that was presented one cycle earlier.
- R9: The fetch flag is high exactly when the previous cycle's step field was zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| opcode_i | input | 8 | Opcode offered for capture |
| ucode_word_i | input | 16 | Word read from the external microcode array |
| ucode_addr_o | output | 12 | Microcode address {opcode, step} |
| ctrl_o | output | 16 | Registered control lines |
| fetch_o | output | 1 | Control word came from step zero |

## Verification
The bench emulates the microcode array with a closed-form function of the address. It then walks more than one full pass over all 256 opcodes. Instruction lengths cycle from 2 to 16 steps, which separates early termination (R4) from plain advance (R3). One opcode class never sets the end bit, so the counter must wrap on its own (R5); a length-16 program that ends by the end bit does not show this. Every third opcode carries a stray load bit at step one; because the opcode input always differs from the latched opcode at that point, a leaking load is visible in the address (R7). A reset in the middle of an instruction checks that reset restarts the sequence from address zero.

// File: rtl/useq_pkg.sv
package useq_pkg;
   localparam int unsigned OPC_W_DEF   = 8;
   localparam int unsigned STEP_W_DEF  = 4;
   localparam int unsigned WORD_W_DEF  = 16;
   localparam int unsigned END_BIT_DEF  = 15;
   localparam int unsigned LOAD_BIT_DEF = 14;

   // How a sequencing step was taken; used for readability of next-state logic.
   typedef enum logic [1:0] {
      STEP_ADV  = 2'd0,
      STEP_END  = 2'd1,
      STEP_WRAP = 2'd2
   } step_kind_e;
endpackage

// File: rtl/useq_step_ctr.sv
module useq_step_ctr
   import useq_pkg::*;
#(
   parameter int unsigned STEP_W = STEP_W_DEF
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              end_req_i,
   output logic [STEP_W-1:0] step_o,
   output logic              at_zero_o
);
   localparam logic [STEP_W-1:0] STEP_LAST = {STEP_W{1'b1}};

   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] step_d;
   step_kind_e        kind;

   always_comb begin
      if (end_req_i) begin
         kind = STEP_END;
      end else if (step_q == STEP_LAST) begin
         kind = STEP_WRAP;
      end else begin
         kind = STEP_ADV;
      end
   end

   always_comb begin
      case (kind)
         STEP_ADV: step_d = step_q + {{(STEP_W-1){1'b0}}, 1'b1};
         default:  step_d = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         step_q <= '0;
      end else begin
         step_q <= step_d;
      end
   end

   assign step_o    = step_q;
   assign at_zero_o = (step_q == '0);
endmodule

// File: rtl/useq_opcode_reg.sv
module useq_opcode_reg
   import useq_pkg::*;
#(
   parameter int unsigned OPC_W = OPC_W_DEF
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             at_zero_i,
   input  logic             load_req_i,
   input  logic [OPC_W-1:0] opcode_i,
   output logic [OPC_W-1:0] opcode_o
);
   logic [OPC_W-1:0] opc_q;
   logic             take;

   assign take = at_zero_i & load_req_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         opc_q <= '0;
      end else if (take) begin
         opc_q <= opcode_i;
      end
   end

   assign opcode_o = opc_q;
endmodule

// File: rtl/useq_word_reg.sv
module useq_word_reg
   import useq_pkg::*;
#(
   parameter int unsigned WORD_W  = WORD_W_DEF,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              at_zero_i,
   output logic [WORD_W-1:0] ctrl_o,
   output logic              fetch_o
);
   generate
      if (OUT_REG) begin : g_reg
         logic [WORD_W-1:0] ctrl_q;
         logic              fetch_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               ctrl_q  <= '0;
               fetch_q <= 1'b0;
            end else begin
               ctrl_q  <= word_i;
               fetch_q <= at_zero_i;
            end
         end
         assign ctrl_o  = ctrl_q;
         assign fetch_o = fetch_q;
      end else begin : g_pass
         assign ctrl_o  = rst_i ? '0 : word_i;
         assign fetch_o = ~rst_i & at_zero_i;
      end
   endgenerate
endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int unsigned OPC_W    = OPC_W_DEF,
   parameter int unsigned STEP_W   = STEP_W_DEF,
   parameter int unsigned WORD_W   = WORD_W_DEF,
   parameter int unsigned END_BIT  = END_BIT_DEF,
   parameter int unsigned LOAD_BIT = LOAD_BIT_DEF,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic [7:0]              opcode_i,
   input  logic [15:0]             ucode_word_i,
   output logic [11:0]             ucode_addr_o,
   output logic [15:0]             ctrl_o,
   output logic                    fetch_o
);
   localparam int unsigned ADDR_W = OPC_W + STEP_W;

   generate
      if (OPC_W != 8 || STEP_W != 4 || WORD_W != 16) begin : g_bad_width
         $error("useq_top: port widths are fixed at 8/4/16");
      end
      if (END_BIT >= WORD_W || LOAD_BIT >= WORD_W) begin : g_bad_bit
         $error("useq_top: control bit position outside the word");
      end
      if (END_BIT == LOAD_BIT) begin : g_same_bit
         $error("useq_top: end and load bits must differ");
      end
      if (ADDR_W != 12) begin : g_bad_addr
         $error("useq_top: address width must be 12");
      end
   endgenerate

   logic [STEP_W-1:0] step;
   logic              at_zero;
   logic [OPC_W-1:0]  opcode;
   logic              end_req;
   logic              load_req;

   assign end_req  = ucode_word_i[END_BIT];
   assign load_req = ucode_word_i[LOAD_BIT];

   useq_step_ctr #(
      .STEP_W (STEP_W)
   ) step_i (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .end_req_i (end_req),
      .step_o    (step),
      .at_zero_o (at_zero)
   );

   useq_opcode_reg #(
      .OPC_W (OPC_W)
   ) opc_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .at_zero_i  (at_zero),
      .load_req_i (load_req),
      .opcode_i   (opcode_i),
      .opcode_o   (opcode)
   );

   useq_word_reg #(
      .WORD_W  (WORD_W),
      .OUT_REG (OUT_REG)
   ) word_i (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .word_i    (ucode_word_i),
      .at_zero_i (at_zero),
      .ctrl_o    (ctrl_o),
      .fetch_o   (fetch_o)
   );

   assign ucode_addr_o = {opcode, step};
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
   parameter int unsigned END_BIT  = 15,
   parameter int unsigned LOAD_BIT = 14,
   parameter bit          OUT_REG  = 1'b1
) (
   input logic        clk_i,
   input logic        rst_i,
   input logic [7:0]  opcode_i,
   input logic [15:0] ucode_word_i,
   input logic [11:0] ucode_addr_o,
   input logic [15:0] ctrl_o,
   input logic        fetch_o
);
   // R1: reset drives address and outputs to zero
   a_r1_reset_zero: assert property (@(posedge clk_i)
      rst_i |=> (ucode_addr_o == 12'd0));

   // R3: advance by one when end bit is clear
   a_r3_advance: assert property (@(posedge clk_i) disable iff (rst_i)
      !ucode_word_i[END_BIT] |=> (ucode_addr_o[3:0] == $past(ucode_addr_o[3:0]) + 4'd1));

   // R4: end bit returns step to zero
   a_r4_end_clears: assert property (@(posedge clk_i) disable iff (rst_i)
      ucode_word_i[END_BIT] |=> (ucode_addr_o[3:0] == 4'd0));

   // R5: wrap from the last step
   a_r5_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
      (!ucode_word_i[END_BIT] && ucode_addr_o[3:0] == 4'hF) |=> (ucode_addr_o[3:0] == 4'd0));

   // R6: load at step zero captures the opcode input
   a_r6_load: assert property (@(posedge clk_i) disable iff (rst_i)
      (ucode_word_i[LOAD_BIT] && ucode_addr_o[3:0] == 4'd0)
         |=> (ucode_addr_o[11:4] == $past(opcode_i)));

   // R7: opcode holds at nonzero steps
   a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (ucode_addr_o[3:0] != 4'd0) |=> $stable(ucode_addr_o[11:4]));

   generate
      if (OUT_REG) begin : g_reg_chk
         // R8: one cycle from word to control lines
         a_r8_latency: assert property (@(posedge clk_i) disable iff (rst_i)
            !rst_i |=> (ctrl_o == $past(ucode_word_i)));
         // R9: fetch flag follows step zero
         a_r9_fetch: assert property (@(posedge clk_i) disable iff (rst_i)
            !rst_i |=> (fetch_o == ($past(ucode_addr_o[3:0]) == 4'd0)));
      end
   endgenerate
endmodule

bind useq_top useq_checker #(
   .END_BIT  (END_BIT),
   .LOAD_BIT (LOAD_BIT),
   .OUT_REG  (OUT_REG)
) chk_i (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .opcode_i     (opcode_i),
   .ucode_word_i (ucode_word_i),
   .ucode_addr_o (ucode_addr_o),
   .ctrl_o       (ctrl_o),
   .fetch_o      (fetch_o)
);

// File: tb/useq_top_tb_top.sv
module useq_top_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  opc = 8'd0;
   logic [15:0] word;
   logic [11:0] addr;
   logic [15:0] ctrl;
   logic        fetch;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   useq_top dut_i (
      .clk_i        (clk),
      .rst_i        (rst),
      .opcode_i     (opc),
      .ucode_word_i (word),
      .ucode_addr_o (addr),
      .ctrl_o       (ctrl),
      .fetch_o      (fetch)
   );

   // Emulated microcode array: bit 15 end, bit 14 load.
   function automatic logic [15:0] rom_fn(input logic [11:0] a);
      int op, st, len;
      logic e, l;
      logic [13:0] low;
      op  = int'(a[11:4]);
      st  = int'(a[3:0]);
      len = 2 + (op % 15);
      e   = (op % 17 != 5) && (st == len - 1);
      l   = (st == 0) || ((op % 3 == 0) && (st == 1));
      low = 14'((int'(a) * 37 + 5) & 16'h3FFF);
      return {e, l, low};
   endfunction

   assign word = rom_fn(addr);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   logic [7:0]  m_op;
   logic [3:0]  m_st;
   logic [15:0] m_ctrl;
   logic        m_fetch;
   logic [7:0]  nxt_op;

   task automatic model_reset();
      m_op = 8'd0; m_st = 4'd0; m_ctrl = 16'd0; m_fetch = 1'b0;
   endtask

   task automatic run(input int n_loads);
      int loads = 0;
      while (loads < n_loads) begin
         logic [15:0] w;
         logic [7:0]  n_op;
         logic [3:0]  n_st;
         string       lbl;
         w   = rom_fn({m_op, m_st});
         opc = nxt_op;
         n_op = m_op;
         if (m_st == 4'd0 && w[14]) begin
            n_op = opc; lbl = "R6"; loads++; nxt_op = nxt_op + 8'd1;
         end else if (w[14]) lbl = "R7";
         else if (w[15]) lbl = "R4";
         else if (m_st == 4'hF) lbl = "R5";
         else lbl = "R3";
         n_st = w[15] ? 4'd0 : m_st + 4'd1;
         @(negedge clk);
         m_fetch = (m_st == 4'd0);
         m_ctrl  = w;
         m_op    = n_op;
         m_st    = n_st;
         chk({lbl, " R2 addr"}, 32'(addr), 32'({m_op, m_st}));
         chk("R8 ctrl", 32'(ctrl), 32'(m_ctrl));
         chk("R9 fetch", 32'(fetch), 32'(m_fetch));
      end
   endtask

   task automatic reset_check();
      chk("R1 addr", 32'(addr), 32'd0);
      chk("R1 ctrl", 32'(ctrl), 32'd0);
      chk("R1 fetch", 32'(fetch), 32'd0);
   endtask

   initial begin
      nxt_op = 8'd1;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      reset_check();
      rst = 1'b0;
      model_reset();
      run(270);
      // mid-instruction reset
      repeat (2) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      reset_check();
      rst = 1'b0;
      model_reset();
      nxt_op = 8'd200;
      run(20);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule